// File: doc/BRIEF.md
# Shift-Based Circular Triplet Finder

This block looks for three-layer track candidates on a cylindrical detector whose azimuth is divided into a ring of bins. It works in two phases. In the fill phase, hit positions from the two inner layers are written into two bit arrays, one bit per azimuth bin. A start strobe then opens the search phase. In the search phase the block takes outer-layer hits, one per clock.

For each outer hit, both inner arrays are rotated circularly. Each array has its own logarithmic shifter, and each rotation amount is the outer hit's bin scaled by that layer's radius ratio. The rotated patterns go through one shared coincidence network. That network is valid for every outer-hit position because the track geometry is the same under rotation. The block returns one triplet map per outer hit, with one bit per curvature class, for a downstream decoder.

A clear strobe empties both arrays and returns the block to the fill phase for the next event. The block is busy while it is in the search phase.

Top module: `tf_triplet_finder`

## Requirements
- R1: After synchronous reset, `busy`, `map_vld` and `map_out` are all zero and both inner-layer arrays are empty.
- R2: While `busy` is low and `clr` is low, a cycle with `l1_vld` (or `l2_vld`) high sets the bit at `l1_pos` (or `l2_pos`) in that layer's array. Both layers may load in the same cycle, and bits stay set until a clear.
- R3: `start` sampled while `busy` is low and `clr` is low makes `busy` high from the next cycle. `busy` then stays high until a clear, and `start` has no effect while `busy` is high.
- R4: While `busy` is high, `l1_vld`/`l2_vld` have no effect on the arrays.
- R5: An outer hit (`l3_vld`) is accepted only when `busy` is high and `clr` is low. `map_vld` is high exactly in the cycle after each accepted hit, so back-to-back hits give back-to-back results. Hits offered while `busy` is low produce no result.
- R6: Layer k (k = 1, 2) is rotated by s_k = ((p3 * Q_k + 2^(F-1)) >> F) mod N. Here Q_k = floor((R_k * 2^F + R3/2) / R3), p3 is the outer bin and F = 8. The defaults are N = 64, R1 = 100, R2 = 200, R3 = 300.
- R7: The rotated bit at index i is A_k[(i + s_k) mod N]. Bit j of the map (j = 0..NCLASS-1, c = j - NCLASS/2) is the OR, over w = 0..WIN-1, of rot1[(c*D1) mod N] AND rot2[(c*D2 + w) mod N], with all indices wrapping circularly. The defaults are NCLASS = 8, D1 = 1, D2 = 2, WIN = 2.
- R8: `clr` beats every other input. It empties both arrays, makes `busy` low from the next cycle and blocks any outer hit in the same cycle.
- R9: `map_out` changes only in a cycle where `map_vld` is high, and holds its last value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Clear arrays and return to fill phase |
| l1_vld | input | 1 | Layer-1 hit valid |
| l1_pos | input | 6 | Layer-1 azimuth bin |
| l2_vld | input | 1 | Layer-2 hit valid |
| l2_pos | input | 6 | Layer-2 azimuth bin |
| start | input | 1 | Begin search phase |
| l3_vld | input | 1 | Outer-layer hit valid |
| l3_pos | input | 6 | Outer-layer azimuth bin |
| busy | output | 1 | Search phase active |
| map_vld | output | 1 | Triplet map valid |
| map_out | output | 8 | Triplet map, one bit per curvature class |

## Verification
A fill hit changes the array at the next edge and can first influence a result for an outer hit offered one cycle later. `busy` follows `start` or `clr` by one edge. Each triplet map appears one edge after its outer hit is accepted. The bench drives every input at a falling edge and reads the result at the next falling edge, which falls after the single register stage. During a run of back-to-back outer hits it checks the previous hit's map in the same half-cycle in which it presents the next hit.

// File: rtl/tf_pkg.sv
package tf_pkg;

    typedef enum logic {
        ST_FILL   = 1'b0,
        ST_SEARCH = 1'b1
    } tf_state_e;

    // Fixed-point scale factor for a radius ratio, rounded to nearest
    function automatic int ratio_q(input int rk, input int r3, input int frac);
        return (rk * (1 << frac) + r3 / 2) / r3;
    endfunction

    // Circular bin offset for curvature class j
    function automatic int class_off(input int j, input int ncls, input int d,
                                     input int w, input int n);
        int c;
        c = j - ncls / 2;
        return (((c * d + w) % n) + n) % n;
    endfunction

endpackage

// File: rtl/tf_hit_array.sv
module tf_hit_array #(
    parameter int NBINS = 64,
    localparam int PW   = $clog2(NBINS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             we,
    input  logic [PW-1:0]    pos,
    output logic [NBINS-1:0] bits
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            bits <= '0;
        end else if (we) begin
            bits[pos] <= 1'b1;
        end
    end
endmodule

// File: rtl/tf_rotator.sv
module tf_rotator #(
    parameter int NBINS = 64,
    localparam int PW   = $clog2(NBINS)
) (
    input  logic [NBINS-1:0] din,
    input  logic [PW-1:0]    amt,
    output logic [NBINS-1:0] dout
);
    logic [NBINS-1:0] stage [PW+1];

    assign stage[0] = din;

    for (genvar k = 0; k < PW; k++) begin : g_stage
        localparam int STEP = 1 << k;
        for (genvar i = 0; i < NBINS; i++) begin : g_bit
            assign stage[k+1][i] = amt[k] ? stage[k][(i + STEP) % NBINS]
                                          : stage[k][i];
        end
    end

    assign dout = stage[PW];
endmodule

// File: rtl/tf_coinc.sv
module tf_coinc
    import tf_pkg::*;
#(
    parameter int NBINS  = 64,
    parameter int NCLASS = 8,
    parameter int D1     = 1,
    parameter int D2     = 2,
    parameter int WIN    = 2
) (
    input  logic [NBINS-1:0]  rot1,
    input  logic [NBINS-1:0]  rot2,
    output logic [NCLASS-1:0] tmap
);
    for (genvar j = 0; j < NCLASS; j++) begin : g_cls
        localparam int O1 = class_off(j, NCLASS, D1, 0, NBINS);
        logic [WIN-1:0] pair_hit;
        for (genvar w = 0; w < WIN; w++) begin : g_win
            localparam int O2 = class_off(j, NCLASS, D2, w, NBINS);
            assign pair_hit[w] = rot1[O1] & rot2[O2];
        end
        assign tmap[j] = |pair_hit;
    end
endmodule

// File: rtl/tf_triplet_finder.sv
module tf_triplet_finder
    import tf_pkg::*;
#(
    parameter int NBINS  = 64,
    parameter int NCLASS = 8,
    parameter int R1     = 100,
    parameter int R2     = 200,
    parameter int R3     = 300,
    parameter int FRAC   = 8,
    parameter int D1     = 1,
    parameter int D2     = 2,
    parameter int WIN    = 2,
    localparam int PW    = $clog2(NBINS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              l1_vld,
    input  logic [PW-1:0]     l1_pos,
    input  logic              l2_vld,
    input  logic [PW-1:0]     l2_pos,
    input  logic              start,
    input  logic              l3_vld,
    input  logic [PW-1:0]     l3_pos,
    output logic              busy,
    output logic              map_vld,
    output logic [NCLASS-1:0] map_out
);
    localparam int PRODW = PW + FRAC;

    tf_state_e state;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            state <= ST_FILL;
        end else if (state == ST_FILL && start) begin
            state <= ST_SEARCH;
        end
    end

    assign busy = (state == ST_SEARCH);

    logic [1:0]           lay_we;
    logic [PW-1:0]        lay_pos [2];
    logic [NBINS-1:0]     lay_bits [2];
    logic [NBINS-1:0]     lay_rot [2];
    logic [PW-1:0]        lay_shift [2];

    assign lay_we[0]  = l1_vld && !busy && !clr;
    assign lay_we[1]  = l2_vld && !busy && !clr;
    assign lay_pos[0] = l1_pos;
    assign lay_pos[1] = l2_pos;

    for (genvar g = 0; g < 2; g++) begin : g_layer
        localparam int RK = (g == 0) ? R1 : R2;
        localparam int QK = ratio_q(RK, R3, FRAC);
        localparam logic [PRODW-1:0] QV   = PRODW'(QK);
        localparam logic [PRODW-1:0] HALF = PRODW'(1 << (FRAC - 1));

        logic [PRODW-1:0] prod;
        assign prod         = PRODW'(l3_pos) * QV + HALF;
        assign lay_shift[g] = PW'(prod >> FRAC);

        tf_hit_array #(.NBINS(NBINS)) u_arr (
            .clk  (clk),
            .rst  (rst),
            .clr  (clr),
            .we   (lay_we[g]),
            .pos  (lay_pos[g]),
            .bits (lay_bits[g])
        );

        tf_rotator #(.NBINS(NBINS)) u_rot (
            .din  (lay_bits[g]),
            .amt  (lay_shift[g]),
            .dout (lay_rot[g])
        );
    end

    logic [NCLASS-1:0] tmap;

    tf_coinc #(
        .NBINS (NBINS),
        .NCLASS(NCLASS),
        .D1    (D1),
        .D2    (D2),
        .WIN   (WIN)
    ) u_coinc (
        .rot1 (lay_rot[0]),
        .rot2 (lay_rot[1]),
        .tmap (tmap)
    );

    logic accept;
    assign accept = busy && l3_vld && !clr;

    always_ff @(posedge clk) begin
        if (rst) begin
            map_vld <= 1'b0;
            map_out <= '0;
        end else begin
            map_vld <= accept;
            if (accept) begin
                map_out <= tmap;
            end
        end
    end
endmodule

// File: rtl/tf_checker.sv
module tf_checker #(
    parameter int NCLASS = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              clr,
    input logic              start,
    input logic              l3_vld,
    input logic              busy,
    input logic              map_vld,
    input logic [NCLASS-1:0] map_out
);
    // R5
    result_due_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && l3_vld && !clr) |=> map_vld);

    // R5
    result_cause_chk: assert property (@(posedge clk) disable iff (rst)
        map_vld |-> $past(busy && l3_vld && !clr));

    // R3
    enter_search_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && !clr) |=> busy);

    // R3
    stay_search_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !clr) |=> busy);

    // R8
    clear_exit_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (!busy && !map_vld));

    // R9
    map_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !map_vld |-> $stable(map_out));
endmodule

bind tf_triplet_finder tf_checker #(.NCLASS(NCLASS)) u_tf_chk (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr),
    .start   (start),
    .l3_vld  (l3_vld),
    .busy    (busy),
    .map_vld (map_vld),
    .map_out (map_out)
);

// File: tb/tf_triplet_finder_test.sv
`timescale 1ns/1ps
module tf_triplet_finder_test;
    localparam int N = 64, NC = 8, R1 = 100, R2 = 200, R3 = 300;
    localparam int D1 = 1, D2 = 2, WIN = 2;

    logic clk = 1'b0, rst = 1'b1, clr = 1'b0;
    logic l1_vld = 1'b0, l2_vld = 1'b0, start = 1'b0, l3_vld = 1'b0;
    logic [5:0] l1_pos = '0, l2_pos = '0, l3_pos = '0;
    logic busy, map_vld;
    logic [NC-1:0] map_out;

    int nchk = 0, nfail = 0;
    logic [N-1:0] m1, m2;
    logic m_busy;
    logic [NC-1:0] last_map;

    always #5 clk = ~clk;

    tf_triplet_finder uut (
        .clk(clk), .rst(rst), .clr(clr),
        .l1_vld(l1_vld), .l1_pos(l1_pos),
        .l2_vld(l2_vld), .l2_pos(l2_pos),
        .start(start), .l3_vld(l3_vld), .l3_pos(l3_pos),
        .busy(busy), .map_vld(map_vld), .map_out(map_out)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [NC-1:0] exp_map(input int p3);
        logic [NC-1:0] r;
        int q1, q2, s1, s2, c, o1, o2;
        q1 = (R1 * 256 + R3 / 2) / R3;
        q2 = (R2 * 256 + R3 / 2) / R3;
        s1 = ((p3 * q1 + 128) >> 8) % N;
        s2 = ((p3 * q2 + 128) >> 8) % N;
        r = '0;
        for (int j = 0; j < NC; j++) begin
            c = j - NC / 2;
            o1 = (((c * D1) % N) + N) % N;
            for (int w = 0; w < WIN; w++) begin
                o2 = (((c * D2 + w) % N) + N) % N;
                if (m1[(o1 + s1) % N] && m2[(o2 + s2) % N]) r[j] = 1'b1;
            end
        end
        return r;
    endfunction

    task automatic tick();
        @(negedge clk);
        clr = 0; l1_vld = 0; l2_vld = 0; start = 0; l3_vld = 0;
    endtask

    task automatic do_clear();
        tick(); clr = 1; m1 = '0; m2 = '0; m_busy = 0;
        tick();
        chk("R8 busy after clear", 64'(busy), 64'd0);
    endtask

    task automatic fill(input int p1, input bit v1, input int p2, input bit v2);
        tick();
        l1_vld = v1; l1_pos = 6'(p1); l2_vld = v2; l2_pos = 6'(p2);
        if (!m_busy) begin
            if (v1) m1[p1] = 1'b1;
            if (v2) m2[p2] = 1'b1;
        end
    endtask

    task automatic go();
        tick(); start = 1; m_busy = 1;
        tick();
        chk("R3 busy after start", 64'(busy), 64'd1);
    endtask

    // back-to-back outer hits, each result checked one cycle later
    task automatic search(input int p [], input string req);
        logic [NC-1:0] e;
        for (int i = 0; i <= p.size(); i++) begin
            tick();
            if (i > 0) begin
                chk({req, " map_vld"}, 64'(map_vld), 64'd1);
                chk({req, " map"}, 64'(map_out), 64'(e));
                last_map = e;
            end
            if (i < p.size()) begin
                e = exp_map(p[i]);
                l3_vld = 1; l3_pos = 6'(p[i]);
            end
        end
    endtask

    task automatic t_reset();
        chk("R1 busy", 64'(busy), 64'd0);
        chk("R1 map_vld", 64'(map_vld), 64'd0);
        chk("R1 map_out", 64'(map_out), 64'd0);
    endtask

    task automatic t_basic();
        do_clear();
        fill(10, 1, 20, 1);
        go();
        chk("R6 expected class", 64'(exp_map(30)), 64'h10);
        search('{30, 31, 0}, "R6 R7 basic");
    endtask

    task automatic t_wrap();
        do_clear();
        fill(62, 1, 60, 1);
        fill(1, 1, 3, 1);
        fill(0, 0, 63, 1);
        go();
        search('{63, 1, 50, 5, 62}, "R7 wrap");
    endtask

    task automatic t_dense();
        int a, b;
        do_clear();
        a = 7; b = 19;
        for (int i = 0; i < 20; i++) begin
            a = (a * 5 + 3) % N; b = (b * 13 + 11) % N;
            fill(a, 1, b, (i % 3) != 0);
        end
        go();
        search('{0, 8, 16, 24, 33, 41, 50, 58, 63}, "R2 dense");
    endtask

    task automatic t_busy_ignore();
        do_clear();
        fill(10, 1, 20, 1);
        go();
        fill(11, 1, 22, 1);
        fill(9, 1, 18, 1);
        tick(); start = 1;
        tick();
        chk("R3 start while busy", 64'(busy), 64'd1);
        search('{30, 33, 27}, "R4 busy ignore");
    endtask

    task automatic t_idle_l3();
        logic [NC-1:0] held;
        do_clear();
        fill(10, 1, 20, 1);
        held = map_out;
        tick(); l3_vld = 1; l3_pos = 6'd30;
        tick();
        chk("R5 no result idle", 64'(map_vld), 64'd0);
        chk("R9 map held idle", 64'(map_out), 64'(held));
    endtask

    task automatic t_clear_search();
        logic [NC-1:0] held;
        do_clear();
        fill(10, 1, 20, 1);
        go();
        search('{30}, "R5 single");
        held = map_out;
        tick(); clr = 1; l3_vld = 1; l3_pos = 6'd30;
        m1 = '0; m2 = '0; m_busy = 0;
        tick();
        chk("R8 clr blocks hit", 64'(map_vld), 64'd0);
        chk("R8 busy low", 64'(busy), 64'd0);
        chk("R9 map held", 64'(map_out), 64'(held));
        go();
        search('{30}, "R8 arrays cleared");
        chk("R8 empty map", 64'(map_out), 64'd0);
    endtask

    task automatic t_hold();
        do_clear();
        fill(5, 1, 10, 1);
        go();
        search('{15}, "R5 hold setup");
        tick(); tick(); tick();
        chk("R9 hold after idle", 64'(map_out), 64'(last_map));
        chk("R5 vld low idle", 64'(map_vld), 64'd0);
    endtask

    initial begin
        m1 = '0; m2 = '0; m_busy = 0; last_map = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_basic();
        t_wrap();
        t_dense();
        t_busy_ignore();
        t_idle_l3();
        t_clear_search();
        t_hold();
        tick();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        #1000000;
        nchk++; nfail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule